// File: doc/BRIEF.md
# UART Channel Loopback Mode Controller

This block sits between one UART channel's transmitter and receiver engines and the channel's serial pins. A 2-bit mode request selects one of four routings: normal, automatic echo, local loopback and remote loopback. For each routing the block chooses three things:

- what drives the TxD pin;
- what feeds the receiver's serial input;
- which 1x bit tick clocks each engine.

It also decides whether host character writes reach the transmitter and whether received characters reach the host.

The applied mode is held in a four-state machine with states ST_NORMAL, ST_ECHO, ST_LOCAL and ST_REMOTE. There is one transition, named SWITCH, from any state to the state encoded by the request. SWITCH is taken on a clock edge only when three conditions hold: the request differs from the applied mode, the receiver is idle and the transmitter is idle. When the request matches the applied mode, or when either engine is busy, the machine takes HOLD and keeps its state. All routing outputs are combinational functions of the applied state and the live inputs.

Top module: `uart_loopback_ctrl`

## Requirements
- R1: After reset, the applied mode `mode_cur` is normal (code 00). Encoding: 00 normal, 01 automatic echo, 10 local loopback, 11 remote loopback.
- R2: A new `mode_req` becomes `mode_cur` on the next clock edge only if `rx_busy` and `tx_busy` were both low before that edge. Otherwise `mode_cur` keeps its value.
- R3: In normal mode, `txd_pin` follows `tx_ser` and `rx_ser` follows `rxd_pin`. Host writes pass to the transmitter load port (`tx_load`, `tx_load_data`), and received characters pass to `rx_deliver`.
- R4: In normal mode, `rx_tick` follows `rx_tick_src` and `tx_tick` follows `tx_tick_src`.
- R5: In automatic echo mode, `tx_load` and `tx_load_data` follow `rx_char_valid` and `rx_char_data`, and host writes have no effect. The serial paths are as in normal mode, and `rx_deliver` still follows `rx_char_valid`.
- R6: In automatic echo mode, both `rx_tick` and `tx_tick` follow `rx_tick_src`.
- R7: In local loopback mode, `rx_ser` follows `tx_ser`, `rxd_pin` has no effect, and `txd_pin` is held at 1.
- R8: In local loopback mode, both ticks follow `tx_tick_src`. The host load and delivery paths behave as in normal mode.
- R9: In remote loopback mode, `txd_pin` follows `rxd_pin` and `rx_ser` is held at 1. `rx_deliver` and `tx_load` are 0, `tx_load_data` is 0, and each tick follows its own source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req | input | 2 | Requested mode code |
| rx_busy | input | 1 | Receiver engine mid-frame |
| tx_busy | input | 1 | Transmitter engine mid-frame |
| mode_cur | output | 2 | Applied mode code |
| rxd_pin | input | 1 | Serial input pin |
| txd_pin | output | 1 | Serial output pin |
| tx_ser | input | 1 | Transmitter engine serial output |
| rx_ser | output | 1 | Receiver engine serial input |
| rx_tick_src | input | 1 | Receiver 1x tick from baud generator |
| tx_tick_src | input | 1 | Transmitter 1x tick from baud generator |
| rx_tick | output | 1 | 1x tick driving the receiver engine |
| tx_tick | output | 1 | 1x tick driving the transmitter engine |
| host_wr | input | 1 | Host character write strobe |
| host_data | input | DATA_W | Host character |
| rx_char_valid | input | 1 | Receiver captured a character |
| rx_char_data | input | DATA_W | Captured character |
| tx_load | output | 1 | Load strobe into the transmitter |
| tx_load_data | output | DATA_W | Character loaded into the transmitter |
| rx_deliver | output | 1 | Captured character passed to the host |

## Verification
The assertions check these rules on every cycle:

- the applied mode never changes across an edge that follows a busy cycle;
- TxD stays high in local loopback;
- remote loopback never loads or delivers a character;
- in automatic echo, a lone host write never produces a load.

Only the bench's scenarios can show the rest. That covers the full routing table under varied data and tick patterns, and the fact that RxD has no effect in local loopback. It also covers the timing of a mode switch that is deferred across a run of busy cycles and then lands on the first idle edge.

// File: rtl/uart_lb_pkg.sv
package uart_lb_pkg;
    typedef enum logic [1:0] {
        ST_NORMAL = 2'b00,
        ST_ECHO   = 2'b01,
        ST_LOCAL  = 2'b10,
        ST_REMOTE = 2'b11
    } lb_state_e;
endpackage

// File: rtl/lb_mode_fsm.sv
module lb_mode_fsm
    import uart_lb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_req,
    input  logic       rx_busy,
    input  logic       tx_busy,
    output lb_state_e  state_q
);
    lb_state_e state_d;
    logic      both_idle;

    assign both_idle = !rx_busy && !tx_busy;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_NORMAL;
        else        state_q <= state_d;
    end

    // Next state: SWITCH when idle and the request differs, otherwise HOLD
    always_comb begin
        state_d = state_q;
        if (both_idle && (mode_req != state_q)) begin
            unique case (mode_req)
                2'b00: state_d = ST_NORMAL;
                2'b01: state_d = ST_ECHO;
                2'b10: state_d = ST_LOCAL;
                2'b11: state_d = ST_REMOTE;
            endcase
        end
    end

    // R2
    mode_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_busy || tx_busy) |=> $stable(state_q));
endmodule

// File: rtl/lb_path_mux.sv
module lb_path_mux
    import uart_lb_pkg::*;
(
    input  lb_state_e state,
    input  logic      rxd_pin,
    input  logic      tx_ser,
    input  logic      rx_tick_src,
    input  logic      tx_tick_src,
    output logic      txd_pin,
    output logic      rx_ser,
    output logic      rx_tick,
    output logic      tx_tick
);
    always_comb begin
        txd_pin = tx_ser;
        rx_ser  = rxd_pin;
        rx_tick = rx_tick_src;
        tx_tick = tx_tick_src;
        unique case (state)
            ST_NORMAL: ;
            ST_ECHO: begin
                tx_tick = rx_tick_src;
            end
            ST_LOCAL: begin
                txd_pin = 1'b1;
                rx_ser  = tx_ser;
                rx_tick = tx_tick_src;
            end
            ST_REMOTE: begin
                txd_pin = rxd_pin;
                rx_ser  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/lb_char_feed.sv
module lb_char_feed
    import uart_lb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  lb_state_e         state,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_data,
    input  logic              rx_char_valid,
    input  logic [DATA_W-1:0] rx_char_data,
    output logic              tx_load,
    output logic [DATA_W-1:0] tx_load_data,
    output logic              rx_deliver
);
    always_comb begin
        tx_load      = host_wr;
        tx_load_data = host_data;
        rx_deliver   = rx_char_valid;
        unique case (state)
            ST_NORMAL, ST_LOCAL: ;
            ST_ECHO: begin
                tx_load      = rx_char_valid;
                tx_load_data = rx_char_data;
            end
            ST_REMOTE: begin
                tx_load      = 1'b0;
                tx_load_data = '0;
                rx_deliver   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/uart_loopback_ctrl.sv
module uart_loopback_ctrl
    import uart_lb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_req,
    input  logic              rx_busy,
    input  logic              tx_busy,
    output logic [1:0]        mode_cur,
    input  logic              rxd_pin,
    output logic              txd_pin,
    input  logic              tx_ser,
    output logic              rx_ser,
    input  logic              rx_tick_src,
    input  logic              tx_tick_src,
    output logic              rx_tick,
    output logic              tx_tick,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_data,
    input  logic              rx_char_valid,
    input  logic [DATA_W-1:0] rx_char_data,
    output logic              tx_load,
    output logic [DATA_W-1:0] tx_load_data,
    output logic              rx_deliver
);
    lb_state_e state;

    lb_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_req (mode_req),
        .rx_busy  (rx_busy),
        .tx_busy  (tx_busy),
        .state_q  (state)
    );

    lb_path_mux u_mux (
        .state       (state),
        .rxd_pin     (rxd_pin),
        .tx_ser      (tx_ser),
        .rx_tick_src (rx_tick_src),
        .tx_tick_src (tx_tick_src),
        .txd_pin     (txd_pin),
        .rx_ser      (rx_ser),
        .rx_tick     (rx_tick),
        .tx_tick     (tx_tick)
    );

    lb_char_feed #(.DATA_W(DATA_W)) u_feed (
        .state         (state),
        .host_wr       (host_wr),
        .host_data     (host_data),
        .rx_char_valid (rx_char_valid),
        .rx_char_data  (rx_char_data),
        .tx_load       (tx_load),
        .tx_load_data  (tx_load_data),
        .rx_deliver    (rx_deliver)
    );

    assign mode_cur = state;

    // R7
    local_txd_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCAL) |-> txd_pin);

    // R9
    remote_no_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REMOTE) |-> (!tx_load && !rx_deliver));

    // R5
    echo_host_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ECHO && host_wr && !rx_char_valid) |-> !tx_load);

    // R6
    echo_tick_share_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ECHO) |-> (tx_tick == rx_tick));
endmodule

// File: tb/uart_loopback_ctrl_test.sv
module uart_loopback_ctrl_test;
    localparam int PERIOD = 10;
    localparam int DW     = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode_req = 2'b00;
    logic          rx_busy = 1'b0, tx_busy = 1'b0;
    logic [1:0]    mode_cur;
    logic          rxd_pin = 1'b1, txd_pin, tx_ser = 1'b1, rx_ser;
    logic          rx_tick_src = 1'b0, tx_tick_src = 1'b0, rx_tick, tx_tick;
    logic          host_wr = 1'b0;
    logic [DW-1:0] host_data = '0;
    logic          rx_char_valid = 1'b0;
    logic [DW-1:0] rx_char_data = '0;
    logic          tx_load;
    logic [DW-1:0] tx_load_data;
    logic          rx_deliver;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;
    bit  cmp_en = 1'b0;
    int  ref_mode = 0;

    uart_loopback_ctrl #(.DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .mode_req(mode_req),
        .rx_busy(rx_busy), .tx_busy(tx_busy), .mode_cur(mode_cur),
        .rxd_pin(rxd_pin), .txd_pin(txd_pin), .tx_ser(tx_ser), .rx_ser(rx_ser),
        .rx_tick_src(rx_tick_src), .tx_tick_src(tx_tick_src),
        .rx_tick(rx_tick), .tx_tick(tx_tick),
        .host_wr(host_wr), .host_data(host_data),
        .rx_char_valid(rx_char_valid), .rx_char_data(rx_char_data),
        .tx_load(tx_load), .tx_load_data(tx_load_data), .rx_deliver(rx_deliver)
    );

    always #(PERIOD/2) clk = ~clk;

    // Reference mode register: a switch lands only after an idle cycle
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) ref_mode <= 0;
        else if (!rx_busy && !tx_busy) ref_mode <= int'(mode_req);
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d (mode %0d, t=%0t)",
                     req, what, act, exp, ref_mode, $time);
        end
    endtask

    // Compare against the reference on every falling edge
    always @(negedge clk) begin
        if (cmp_en) begin
            string rq, tk, ch;
            int e_txd, e_rxs, e_rt, e_tt, e_ld, e_ldd, e_dv;
            e_txd = tx_ser; e_rxs = rxd_pin; e_rt = rx_tick_src; e_tt = tx_tick_src;
            e_ld = host_wr; e_ldd = host_data; e_dv = rx_char_valid;
            rq = "R3"; tk = "R4"; ch = "R3";
            case (ref_mode)
                1: begin
                    rq = "R5"; tk = "R6"; ch = "R5";
                    e_tt = rx_tick_src; e_ld = rx_char_valid; e_ldd = rx_char_data;
                end
                2: begin
                    rq = "R7"; tk = "R8"; ch = "R8";
                    e_txd = 1; e_rxs = tx_ser; e_rt = tx_tick_src;
                end
                3: begin
                    rq = "R9"; tk = "R9"; ch = "R9";
                    e_txd = rxd_pin; e_rxs = 1; e_ld = 0; e_ldd = 0; e_dv = 0;
                end
                default: ;
            endcase
            chk("R2", "mode_cur", int'(mode_cur), ref_mode);
            chk(rq, "txd_pin", int'(txd_pin), e_txd);
            chk(rq, "rx_ser", int'(rx_ser), e_rxs);
            chk(tk, "rx_tick", int'(rx_tick), e_rt);
            chk(tk, "tx_tick", int'(tx_tick), e_tt);
            chk(ch, "tx_load", int'(tx_load), e_ld);
            chk(ch, "tx_load_data", int'(tx_load_data), e_ldd);
            chk(ch, "rx_deliver", int'(rx_deliver), e_dv);
        end
    end

    task automatic drive_random(input int busy_pct);
        @(posedge clk); #1;
        rxd_pin       = 1'($urandom);
        tx_ser        = 1'($urandom);
        rx_tick_src   = 1'($urandom);
        tx_tick_src   = 1'($urandom);
        host_wr       = 1'($urandom);
        host_data     = DW'($urandom);
        rx_char_valid = 1'($urandom);
        rx_char_data  = DW'($urandom);
        rx_busy       = (($urandom % 100) < busy_pct);
        tx_busy       = (($urandom % 100) < busy_pct);
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state is normal
        chk("R1", "mode_cur after reset", int'(mode_cur), 0);
        cmp_en = 1'b1;

        // Directed deferral (R2): request local loopback while busy
        @(posedge clk); #1;
        mode_req = 2'b10; rx_busy = 1'b1; tx_busy = 1'b0;
        repeat (4) @(posedge clk);
        #1 rx_busy = 1'b0; tx_busy = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R2", "held while busy", int'(mode_cur), 0);
        @(posedge clk); #1 tx_busy = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R2", "switch after idle", int'(mode_cur), 2);

        // Each mode in turn with random traffic and no busy (R3..R9)
        for (int m = 0; m < 4; m++) begin
            @(posedge clk); #1;
            mode_req = 2'(m); rx_busy = 1'b0; tx_busy = 1'b0;
            @(posedge clk);
            @(negedge clk);
            chk("R2", "mode applied", int'(mode_cur), m);
            for (int i = 0; i < 300; i++) drive_random(0);
        end

        // Local loopback: RxD toggled while everything else is held (R7)
        @(posedge clk); #1;
        mode_req = 2'b10; rx_busy = 1'b0; tx_busy = 1'b0; tx_ser = 1'b0;
        @(posedge clk);
        for (int i = 0; i < 6; i++) begin
            @(posedge clk); #1 rxd_pin = ~rxd_pin;
            @(negedge clk);
            chk("R7", "rx_ser ignores rxd", int'(rx_ser), 0);
            chk("R7", "txd held high", int'(txd_pin), 1);
        end

        // Random mode requests with busy activity (R2 with everything)
        for (int i = 0; i < 1500; i++) begin
            if (i % 7 == 0) begin
                @(posedge clk); #1 mode_req = 2'($urandom);
            end
            drive_random(40);
        end

        @(posedge clk);
        @(negedge clk);
        cmp_en = 1'b0;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule